// File: doc/BRIEF.md
# SAR Conversion and Serial Output Sequencer

This block is the digital control core of a 12-bit successive-approximation converter whose result leaves on a three-wire serial link. It watches an active-low chip select and a data clock, both sampled by a faster system clock. From them it derives the track period of the sampling switch, the twelve bit trials presented to the charge-redistribution array, and the serial data output with its driver enable. Each bit is put on the line in the same data-clock period in which it is decided, so the first result bit appears with no pipeline delay.

After the last trial, the analog comparator and bias are powered down. The data clock can still shift the stored result out a second time, starting from bit 1 and ending with the top bit. After that the output driver releases the line and stays quiet until chip select is cycled. Raising chip select at any moment abandons the conversion and puts the whole block, including its digital part, into full shutdown.

The comparator, capacitor array and sample switch are outside the block. They see only the trial code, the sample enable and the analog power-down flag, and they return a one-bit decision.

Top module: `sar_serial_sequencer`

## Requirements
- R1: When chip select goes low while the block is idle, `sample_en` rises and `dig_pd` falls. `sample_en` stays high until the second falling data-clock edge counted from then, and the output driver stays disabled meanwhile.
- R2: On that second falling edge, `sample_en` drops, `sdo_oe` rises and `sdo` drives 0 as a null bit for one data-clock period. Whenever `sdo_oe` is low, `sdo` is 0.
- R3: The trial code starts at 0x800. On each rising data-clock edge during conversion, the bit under test is kept if `cmp_hi` is 1 and cleared if it is 0, and the next lower bit is set. The final code is the straight-binary code of the largest trial not above the input.
- R4: Falling edges 3 to 14 each place one decided bit on `sdo`, MSB first. Each bit goes out at the falling edge that follows its own decision.
- R5: Falling edges 15 to 25 replay bits 1 through 11 in that order. Edge 26 drives `sdo_oe` low, and later data-clock edges change no output.
- R6: `cmp_pd` is high while idle and from the falling edge that outputs bit 0 until chip select rises. It is low during sampling, the null bit and the twelve trials.
- R7: `dig_pd` is high exactly while the block is idle. In that state the trial code reads 0.
- R8: Chip select going high in any state aborts the sequence. On the next clock `sdo_oe` is 0, `sample_en` is 0 and `dig_pd` is 1. Data-clock edges while chip select is high have no effect.
- R9: Once a sequence has ended with chip select still low, further data-clock edges never start a new sample. A new conversion needs chip select to go high and then low again.
- R10: After reset, `sdo_oe`, `sdo` and `sample_en` are 0, `cmp_pd` and `dig_pd` are 1, and the trial code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; high requests full shutdown |
| dclk | input | 1 | Serial data clock, synchronous to clk |
| cmp_hi | input | 1 | Comparator decision: 1 when the input is at or above the trial level |
| trial_code | output | 12 | Trial code for the capacitor array |
| sample_en | output | 1 | Sample switch closed (input tracked) |
| cmp_pd | output | 1 | Comparator and bias power-down |
| dig_pd | output | 1 | Full shutdown of the digital section |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial output driver enable (low means high impedance) |

## Verification
The bound assertions watch the per-cycle rules on every clock. They check that a disabled driver carries 0, that chip select high forces shutdown one clock later, that sampling never overlaps power-down or an active driver, that full shutdown keeps the trial code at 0, and that sampling is only ever entered from shutdown. The bench's scenarios cover the ordering properties that need a whole sequence. These are the null bit landing on the second falling edge, each decided bit appearing at the very next falling edge, the mirrored replay, and the release after it. The scenarios also cover the point where the analog power-down switches on, aborts in mid-trial, and the refusal to restart without a chip-select cycle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_NULL,
        ST_CONVERT,
        ST_REPLAY,
        ST_DONE
    } seq_state_e;

    // States in which the comparator and bias may be switched off.
    function automatic logic analog_off(input seq_state_e s);
        return (s == ST_IDLE) || (s == ST_REPLAY) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/sar_dclk_edges.sv
module sar_dclk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk,
    output logic rise_ev,
    output logic fall_ev
);
    logic dclk_d, dclk_q;

    always_comb begin
        dclk_d = dclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dclk_q <= 1'b0;
        else        dclk_q <= dclk_d;
    end

    assign rise_ev = dclk  & ~dclk_q;
    assign fall_ev = ~dclk &  dclk_q;
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int unsigned NBITS = 12,
    localparam int unsigned IDXW = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic             decide,
    input  logic [IDXW-1:0]  idx,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] code
);
    logic [NBITS-1:0] code_d, code_q;

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        localparam logic [IDXW-1:0] SELF  = IDXW'(i);
        localparam logic [IDXW-1:0] ABOVE = IDXW'(i + 1);
        localparam logic            MSB   = (i == NBITS - 1);
        assign code_d[i] = clr                     ? 1'b0   :
                           start                   ? MSB    :
                           (decide && idx == SELF)  ? cmp_hi :
                           (decide && idx == ABOVE) ? 1'b1   :
                                                     code_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    assign code = code_q;
endmodule

// File: rtl/sar_serial_out.sv
module sar_serial_out (
    input  logic clk,
    input  logic rst_n,
    input  logic off,
    input  logic load_null,
    input  logic shift,
    input  logic bit_val,
    output logic sdo,
    output logic sdo_oe
);
    typedef struct packed {
        logic oe;
        logic dat;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (off) begin
            o_d.oe  = 1'b0;
            o_d.dat = 1'b0;
        end else if (load_null) begin
            o_d.oe  = 1'b1;
            o_d.dat = 1'b0;
        end else if (shift) begin
            o_d.dat = bit_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign sdo    = o_q.dat;
    assign sdo_oe = o_q.oe;
endmodule

// File: rtl/sar_serial_sequencer.sv
module sar_serial_sequencer #(
    parameter int unsigned NBITS        = 12,
    parameter int unsigned SAMPLE_FALLS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             dclk,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] trial_code,
    output logic             sample_en,
    output logic             cmp_pd,
    output logic             dig_pd,
    output logic             sdo,
    output logic             sdo_oe
);
    import sar_seq_pkg::*;

    localparam int unsigned IDXW = $clog2(NBITS + 1);
    localparam int unsigned CNTW = $clog2(SAMPLE_FALLS + 1);
    localparam logic [IDXW-1:0] TOP_IDX   = IDXW'(NBITS - 1);
    localparam logic [IDXW-1:0] END_IDX   = IDXW'(NBITS);
    localparam logic [CNTW-1:0] LAST_FALL = CNTW'(SAMPLE_FALLS - 1);

    typedef struct packed {
        seq_state_e      state;
        logic [IDXW-1:0] idx;
        logic [CNTW-1:0] falls;
    } seq_t;

    seq_t st_d, st_q;

    logic rise_ev, fall_ev;
    logic trial_clr, trial_start, decide;
    logic out_off, out_null, out_shift, out_bit;

    sar_dclk_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .dclk    (dclk),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    sar_approx_reg #(.NBITS(NBITS)) u_trial (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (trial_clr),
        .start  (trial_start),
        .decide (decide),
        .idx    (st_q.idx),
        .cmp_hi (cmp_hi),
        .code   (trial_code)
    );

    // Bit currently pointed at by the cursor; zero past the top.
    always_comb begin
        out_bit = 1'b0;
        for (int b = 0; b < NBITS; b++) begin
            if (st_q.idx == IDXW'(b)) out_bit = trial_code[b];
        end
    end

    always_comb begin
        st_d        = st_q;
        trial_clr   = 1'b0;
        trial_start = 1'b0;
        decide      = 1'b0;
        out_off     = 1'b0;
        out_null    = 1'b0;
        out_shift   = 1'b0;
        if (cs_n) begin
            st_d.state = ST_IDLE;
            st_d.idx   = '0;
            st_d.falls = '0;
            trial_clr  = 1'b1;
            out_off    = 1'b1;
        end else begin
            unique case (st_q.state)
                ST_IDLE: begin
                    st_d.state  = ST_SAMPLE;
                    st_d.falls  = '0;
                    trial_start = 1'b1;
                end
                ST_SAMPLE: begin
                    if (fall_ev) begin
                        if (st_q.falls == LAST_FALL) begin
                            st_d.state = ST_NULL;
                            st_d.idx   = TOP_IDX;
                            out_null   = 1'b1;
                        end else begin
                            st_d.falls = st_q.falls + 1'b1;
                        end
                    end
                end
                ST_NULL, ST_CONVERT: begin
                    decide = rise_ev;
                    if (fall_ev) begin
                        out_shift = 1'b1;
                        if (st_q.idx == '0) begin
                            st_d.state = ST_REPLAY;
                            st_d.idx   = IDXW'(1);
                        end else begin
                            st_d.state = ST_CONVERT;
                            st_d.idx   = st_q.idx - 1'b1;
                        end
                    end
                end
                ST_REPLAY: begin
                    if (fall_ev) begin
                        if (st_q.idx == END_IDX) begin
                            st_d.state = ST_DONE;
                            out_off    = 1'b1;
                        end else begin
                            out_shift = 1'b1;
                            st_d.idx  = st_q.idx + 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    st_d = st_q;
                end
                default: begin
                    st_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.idx   <= '0;
            st_q.falls <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sar_serial_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .off       (out_off),
        .load_null (out_null),
        .shift     (out_shift),
        .bit_val   (out_bit),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    assign sample_en = (st_q.state == ST_SAMPLE);
    assign cmp_pd    = analog_off(st_q.state);
    assign dig_pd    = (st_q.state == ST_IDLE);
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
    parameter int unsigned NBITS = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic [NBITS-1:0] trial_code,
    input logic             sample_en,
    input logic             cmp_pd,
    input logic             dig_pd,
    input logic             sdo,
    input logic             sdo_oe
);
    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    a_r8_abort_next: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sdo_oe && !sample_en && dig_pd));

    a_r1_sample_alone: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (!sdo_oe && !cmp_pd && !dig_pd));

    a_r7_shutdown_clear: assert property (@(posedge clk) disable iff (!rst_n)
        dig_pd |-> (trial_code == '0 && cmp_pd && !sdo_oe));

    a_r9_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_en) |-> $past(dig_pd));

    a_r6_analog_on: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp_pd) |-> sample_en);
endmodule

bind sar_serial_sequencer sar_seq_checker #(.NBITS(NBITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .trial_code (trial_code),
    .sample_en  (sample_en),
    .cmp_pd     (cmp_pd),
    .dig_pd     (dig_pd),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe)
);

// File: tb/sim_sar_serial_sequencer.sv
module sim_sar_serial_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;
    localparam int NV         = 7;
    localparam logic [11:0] VEC [NV] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF,
                                         12'hA5A, 12'h123, 12'h555};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        dclk = 1'b0;
    logic [11:0] vin = '0;
    logic [11:0] trial_code;
    logic        sample_en, cmp_pd, dig_pd, sdo, sdo_oe;
    logic        cmp_hi;
    int          errs = 0;
    int          nchk = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Analog-side model: input at or above the trial level.
    assign cmp_hi = (vin >= trial_code);

    sar_serial_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .cmp_hi(cmp_hi),
        .trial_code(trial_code), .sample_en(sample_en), .cmp_pd(cmp_pd),
        .dig_pd(dig_pd), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic dclk_up();
        @(negedge clk) dclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic dclk_down();
        @(negedge clk) dclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic pulse();
        dclk_up();
        dclk_down();
    endtask

    task automatic cs_low();
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_high();
        @(negedge clk) cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic full_conv(input logic [11:0] v);
        vin = v;
        cs_low();
        check(sample_en && !dig_pd && !cmp_pd && !sdo_oe, "R1 sample start",
              {sample_en, dig_pd, cmp_pd, sdo_oe}, 4'b1000);
        pulse();
        check(sample_en && !sdo_oe, "R1 still sampling", {sample_en, sdo_oe}, 2'b10);
        pulse();
        check(!sample_en && sdo_oe && !sdo, "R2 null bit", {sample_en, sdo_oe, sdo}, 3'b010);
        dclk_up();
        check(sdo_oe && !sdo, "R2 null held", {sdo_oe, sdo}, 2'b10);
        check(trial_code[11] == v[11] && trial_code[10], "R3 first trial",
              trial_code[11:10], {v[11], 1'b1});
        dclk_down();
        check(sdo_oe && sdo == v[11], "R4 bit 11", sdo, v[11]);
        for (int b = 10; b >= 0; b--) begin
            pulse();
            check(sdo_oe && sdo == v[b], "R4 msb-first bit", sdo, v[b]);
            check(cmp_pd == (b == 0), "R6 analog pd", cmp_pd, (b == 0));
        end
        check(trial_code == v, "R3 final code", trial_code, v);
        for (int b = 1; b < 12; b++) begin
            pulse();
            check(sdo_oe && sdo == v[b], "R5 replay bit", sdo, v[b]);
        end
        pulse();
        check(!sdo_oe && !sdo && cmp_pd, "R5 release", {sdo_oe, sdo, cmp_pd}, 3'b001);
        for (int k = 0; k < 3; k++) begin
            pulse();
            check(!sdo_oe && !sample_en && trial_code == v && !dig_pd, "R9 no restart",
                  {sdo_oe, sample_en, dig_pd}, 3'b000);
        end
        cs_high();
        check(dig_pd && trial_code == 12'h000 && cmp_pd, "R7 shutdown",
              {dig_pd, cmp_pd, trial_code}, {2'b11, 12'h000});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!sdo_oe && !sdo && !sample_en && cmp_pd && dig_pd && trial_code == 0,
              "R10 reset state", {sdo_oe, sdo, sample_en, cmp_pd, dig_pd}, 5'b00011);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) full_conv(VEC[i]);

        // Abort in the middle of the trials.
        vin = 12'hA5A;
        cs_low();
        repeat (7) pulse();
        check(sdo_oe, "R8 active before abort", sdo_oe, 1);
        cs_high();
        check(!sdo_oe && !sample_en && dig_pd && trial_code == 0, "R8 abort mid",
              {sdo_oe, sample_en, dig_pd}, 3'b001);
        repeat (3) pulse();
        check(!sdo_oe && dig_pd && trial_code == 0, "R8 clocks ignored while high",
              {sdo_oe, dig_pd}, 2'b01);

        // Abort while still sampling.
        cs_low();
        pulse();
        cs_high();
        check(!sample_en && dig_pd, "R8 abort in sample", {sample_en, dig_pd}, 2'b01);

        // Chip select cycled: a fresh conversion runs normally.
        full_conv(12'h3C6);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            nchk++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, nchk);
            $finish;
        end
    end
endmodule